// File: doc/BRIEF.md
# Programmable Clock Gear Divider

This block produces an internal operating clock from an oscillator. It runs on a reference clock `clk` whose every cycle is one half-period of the oscillator; this cycle is called a slot below. A first stage gives a base period of 2 slots, the oscillator rate, or 4 slots, half that rate. A gear stage then stretches the base period by 1, 2, 4 or 8.

The output is not a square wave. Its low phase always lasts half of one base period: 1 slot at the oscillator rate, 2 slots at half rate. The high phase fills the rest of the period. With gear ratio n, the high phase is (1 − n/2) of the period and the low phase is n/2 of it. Example: a 20 MHz oscillator, half rate and gear ×1/4 give a 400 ns period, 350 ns high and 50 ns low. The reset defaults give a 20 MHz output, inside the allowed 5 to 20 MHz range. The processor clock must not go below 5 MHz. The peripheral clock must stay between 10 and 20 MHz. Software must avoid settings that break these limits, because the block does not enforce them.

The select inputs are sampled only in the last slot of an output period. A new setting therefore starts together with a rising edge of the output. The period already under way always completes with its old setting, so a change never produces a shortened pulse.

Top module: `clk_gear_div`

## Requirements
- R1: While `rst` is high, `gclk_out` is 1. Reset selects the oscillator rate and gear code 00 whatever the inputs are. The first period after reset is therefore 1 slot high, 1 slot low. The inputs are first sampled at the end of that period.
- R2: `pre_half` = 0 gives a base period of 2 slots. `pre_half` = 1 gives a base period of 4 slots.
- R3: `gear_code` 2'b00, 2'b01, 2'b10 and 2'b11 make the output period 1, 2, 4 and 8 base periods long.
- R4: The low phase lasts half a base period at every gear: 1 slot when `pre_half` = 0, 2 slots when `pre_half` = 1.
- R5: The high phase lasts the output period minus the low phase: from 1 slot up to 30 slots.
- R6: A change of `pre_half` or `gear_code` during a period does not alter that period. The period ends with its old high and low lengths.
- R7: A setting sampled in the last slot of a period governs the whole next period, starting at the rising edge of `gclk_out`. The internal setting changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle is one oscillator half-period (slot) |
| rst | input | 1 | Synchronous active-high reset |
| pre_half | input | 1 | 0: oscillator rate, 1: half rate |
| gear_code | input | 2 | Gear select: 00 ×1, 01 ×1/2, 10 ×1/4, 11 ×1/8 |
| gclk_out | output | 1 | Divided, asymmetric internal clock |

## Verification
The assertions check the following on every cycle:
- Each low phase lasts 1 or 2 slots.
- No high phase lasts longer than 30 slots.
- The latched setting changes only together with a rising edge of the output.
- The output is high after a reset cycle.

The bench's scenarios show what the assertions cannot:
- The exact high and low lengths for each of the eight settings.
- That a change made in mid-period leaves the running period intact.
- That the reset defaults hold even while the inputs ask for another setting.

// File: rtl/clk_gear_pkg.sv
package clk_gear_pkg;

    parameter int GEAR_W     = 2;
    localparam int MAX_SHIFT = (1 << GEAR_W) - 1;
    localparam int MAX_PERIOD = 4 << MAX_SHIFT;
    localparam int SLOT_W    = $clog2(MAX_PERIOD + 1);
    localparam int MAX_LOW   = 2;
    localparam int MAX_HIGH  = MAX_PERIOD - MAX_LOW;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic              pre_half;
        logic [GEAR_W-1:0] gear;
    } gear_cfg_t;

    localparam gear_cfg_t CFG_RESET = '{pre_half: 1'b0, gear: '0};

    // Base period in slots: 2 at oscillator rate, 4 at half rate.
    function automatic slot_t base_slots(input gear_cfg_t c);
        return c.pre_half ? slot_t'(4) : slot_t'(2);
    endfunction

    function automatic slot_t period_slots(input gear_cfg_t c);
        slot_t b;
        b = base_slots(c);
        return b << c.gear;
    endfunction

    // Low phase is half a base period.
    function automatic slot_t low_slots(input gear_cfg_t c);
        return c.pre_half ? slot_t'(2) : slot_t'(1);
    endfunction

    function automatic slot_t high_slots(input gear_cfg_t c);
        return period_slots(c) - low_slots(c);
    endfunction

endpackage

// File: rtl/gear_cfg_latch.sv
module gear_cfg_latch
    import clk_gear_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              pre_in,
    input  logic [GEAR_W-1:0] gear_in,
    output gear_cfg_t         cfg_q
);

    gear_cfg_t cfg_d;

    always_comb begin
        cfg_d.pre_half = pre_in;
        cfg_d.gear     = gear_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/gear_slot_counter.sv
module gear_slot_counter
    import clk_gear_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t period,
    output slot_t cnt_q,
    output slot_t cnt_inc,
    output logic  wrap
);

    always_comb begin
        cnt_inc = cnt_q + slot_t'(1);
        wrap    = (cnt_inc == period);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/gear_phase_shaper.sv
module gear_phase_shaper
    import clk_gear_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wrap,
    input  slot_t cnt_inc,
    input  slot_t high_len,
    output logic  out_q
);

    logic out_d;

    // Slot 0 of every period is high; later slots stay high until the
    // low tail of the period begins.
    always_comb begin
        if (wrap) begin
            out_d = 1'b1;
        end else begin
            out_d = (cnt_inc < high_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

endmodule

// File: rtl/clk_gear_div.sv
module clk_gear_div
    import clk_gear_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_half,
    input  logic [GEAR_W-1:0] gear_code,
    output logic              gclk_out
);

    gear_cfg_t cfg_q;
    slot_t     period;
    slot_t     high_len;
    slot_t     cnt_q;
    slot_t     cnt_inc;
    logic      wrap;

    always_comb begin
        period   = period_slots(cfg_q);
        high_len = high_slots(cfg_q);
    end

    gear_cfg_latch u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (wrap),
        .pre_in  (pre_half),
        .gear_in (gear_code),
        .cfg_q   (cfg_q)
    );

    gear_slot_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .period  (period),
        .cnt_q   (cnt_q),
        .cnt_inc (cnt_inc),
        .wrap    (wrap)
    );

    gear_phase_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .cnt_inc  (cnt_inc),
        .high_len (high_len),
        .out_q    (gclk_out)
    );

endmodule

// File: rtl/clk_gear_div_chk.sv
module clk_gear_div_chk
    import clk_gear_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              gclk_out,
    input logic              cfg_pre,
    input logic [GEAR_W-1:0] cfg_gear
);

    slot_t lo_run;
    slot_t hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= gclk_out ? '0 : lo_run + slot_t'(1);
            hi_run <= gclk_out ? hi_run + slot_t'(1) : '0;
        end
    end

    // R4: every completed low phase is 1 or 2 slots
    assert_low_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gclk_out) |-> (lo_run == slot_t'(1) || lo_run == slot_t'(2)));

    // R5: high phase never exceeds the longest legal high time
    assert_high_bound_R5: assert property (@(posedge clk) disable iff (rst)
        hi_run <= slot_t'(MAX_HIGH));

    // R7: latched setting changes only with a rising output edge
    assert_cfg_at_rise_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable({cfg_pre, cfg_gear}) |-> $rose(gclk_out));

    // R1: output is high after a reset cycle
    assert_reset_high_R1: assert property (@(posedge clk)
        rst |=> gclk_out);

endmodule

bind clk_gear_div clk_gear_div_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .gclk_out (gclk_out),
    .cfg_pre  (cfg_q.pre_half),
    .cfg_gear (cfg_q.gear)
);

// File: tb/tb_clk_gear_div.sv
`timescale 1ns/1ps
module tb_clk_gear_div;

    logic       clk = 1'b0;
    logic       rst;
    logic       pre_half;
    logic [1:0] gear_code;
    logic       gclk_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    clk_gear_div dut (
        .clk       (clk),
        .rst       (rst),
        .pre_half  (pre_half),
        .gear_code (gear_code),
        .gclk_out  (gclk_out)
    );

    // {pre_half, gear_code, expected high slots, expected low slots}
    localparam int VEC [8][4] = '{
        '{0, 0,  1, 1},
        '{0, 1,  3, 1},
        '{0, 2,  7, 1},
        '{0, 3, 15, 1},
        '{1, 0,  2, 2},
        '{1, 1,  6, 2},
        '{1, 2, 14, 2},
        '{1, 3, 30, 2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Waits for a rising output, then counts its high and low slots.
    task automatic measure(output int h, output int l);
        while (gclk_out !== 1'b0) @(negedge clk);
        while (gclk_out !== 1'b1) @(negedge clk);
        h = 0;
        while (gclk_out === 1'b1) begin h++; @(negedge clk); end
        l = 0;
        while (gclk_out === 1'b0) begin l++; @(negedge clk); end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int h;
        int l;
        rst       = 1'b1;
        pre_half  = 1'b1;
        gear_code = 2'b11;
        repeat (4) @(negedge clk);
        check("R1 out high in reset", int'(gclk_out), 1);

        // Release reset while inputs request half rate, gear x1/8.
        rst = 1'b0;
        @(negedge clk);
        check("R1 default low slot right after reset", int'(gclk_out), 0);
        @(negedge clk);
        h = 0;
        while (gclk_out === 1'b1) begin h++; @(negedge clk); end
        l = 0;
        while (gclk_out === 1'b0) begin l++; @(negedge clk); end
        check("R7 inputs take effect after default period, high", h, 30);
        check("R7 inputs take effect after default period, low", l, 2);

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            pre_half  = VEC[i][0][0];
            gear_code = VEC[i][1][1:0];
            measure(h, l);
            measure(h, l);
            check($sformatf("R3 R5 high pre=%0d gear=%0d", VEC[i][0], VEC[i][1]), h, VEC[i][2]);
            check($sformatf("R2 R4 low pre=%0d gear=%0d", VEC[i][0], VEC[i][1]), l, VEC[i][3]);
        end

        // R6: mid-period change leaves the running period intact
        pre_half  = 1'b1;
        gear_code = 2'b11;
        measure(h, l);
        while (gclk_out !== 1'b0) @(negedge clk);
        while (gclk_out !== 1'b1) @(negedge clk);
        h = 0;
        while (gclk_out === 1'b1) begin
            h++;
            if (h == 5) begin
                pre_half  = 1'b0;
                gear_code = 2'b00;
            end
            @(negedge clk);
        end
        l = 0;
        while (gclk_out === 1'b0) begin l++; @(negedge clk); end
        check("R6 running period keeps high", h, 30);
        check("R6 running period keeps low", l, 2);
        // Slot just sampled is the first slot of the new period.
        check("R7 new period starts high", int'(gclk_out), 1);
        @(negedge clk);
        check("R7 new setting low after 1 slot", int'(gclk_out), 0);
        measure(h, l);
        check("R7 new setting high", h, 1);
        check("R7 new setting low", l, 1);

        // R6 reverse direction: fast to slow, change in the low slot
        while (gclk_out !== 1'b0) @(negedge clk);
        pre_half  = 1'b0;
        gear_code = 2'b10;
        @(negedge clk);
        h = 0;
        while (gclk_out === 1'b1) begin h++; @(negedge clk); end
        check("R7 change in last slot applies at next rise", h, 7);

        // R1: reset mid-run returns to defaults despite inputs
        pre_half  = 1'b1;
        gear_code = 2'b01;
        measure(h, l);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 out high in mid-run reset", int'(gclk_out), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 default period after mid-run reset", int'(gclk_out), 0);
        measure(h, l);
        check("R2 half-rate after reset, high", h, 6);
        check("R4 half-rate after reset, low", l, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule